// File: doc/BRIEF.md
# Serial Potentiometer Wiper Writer

This block loads an 8-bit wiper setting from a parallel input, such as a bank of board switches, into a digitally controlled potentiometer over a transmit-only SPI link. Each transfer is a 16-bit frame. A fixed command byte comes first: the write opcode together with the wiper register address. The wiper value follows it. The whole frame is sent inside one active-low chip-select window.

The serial clock is derived from the system clock by a clock-enable tick, so the block has no clock net of its own. Data moves while the serial clock is low, which means the device samples a settled bit on every rising edge. The slave's data output is not used.

A transfer starts when the synchronized input differs from the last value sent, or when a start strobe arrives while the block is idle. The value is captured once, at frame start. A busy flag covers the frame and the quiet time after it, and a one-cycle done pulse marks the end.

Top module: `wiper_spi_writer`

## Requirements
- R1: After reset, chip select is high, the serial clock and data are low, and busy and done are low. The last value sent is taken as zero.
- R2: The input passes through SYNC_STAGES flops (default 2). While idle, a frame begins on the next clock edge if the synchronized value differs from the last value sent, or if start_i is high.
- R3: A frame is 16 bits sent MSB first: the command byte 8'hDF, then the captured wiper value.
- R4: The serial clock has a half period of CLK_HZ/(2*SCLK_HZ) system cycles (5 by default). It starts low and gives exactly 16 rising edges per frame. It stays low whenever chip select is high.
- R5: The data line changes only while the serial clock is low. The first bit is valid in the same cycle that chip select falls.
- R6: Chip select stays low for the whole frame. It rises together with the serial clock's fall after the 16th rising edge, then stays high for at least GAP_PERIODS serial periods (1 by default) before the next frame.
- R7: busy_o is high from the first cycle of a frame until the end of the quiet time. done_o pulses for one cycle, in the cycle busy_o drops.
- R8: The value is captured at frame start and does not change during the frame. A different value that arrives mid-frame is sent in the next frame.
- R9: A start strobe while busy is ignored. A start strobe while idle resends the current value even if it has not changed.
- R10: The data line is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| value_i | input | 8 | Wiper value (asynchronous, synchronized inside) |
| start_i | input | 1 | Synchronous strobe requesting a write |
| spi_sclk_o | output | 1 | Serial clock to the potentiometer |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to the potentiometer |
| busy_o | output | 1 | Frame or quiet time in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check several rules on every cycle:
- the serial clock is low outside chip select;
- data stays still while the clock is high;
- every frame has exactly 16 rising edges;
- chip select stays high for the minimum quiet time;
- chip select falls only when the block was idle;
- done coincides with busy dropping.

Only the bench scenarios can show that the right bits reach the wire, and that the frame-start rules work. These cover mid-frame value changes being deferred, mid-frame strobes being dropped, and idle strobes resending an unchanged value. A cycle-level reference model and a serial decoder confirm these against the expected frame sequence.

// File: rtl/wiper_spi_pkg.sv
package wiper_spi_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

  // System cycles per serial-clock half period, never below one.
  function automatic int unsigned half_period_cycles(input int unsigned clk_hz,
                                                     input int unsigned sclk_hz);
    int unsigned q;
    q = clk_hz / (2 * sclk_hz);
    if (q < 1) q = 1;
    return q;
  endfunction

  // Bits needed to hold the values 0 .. n-1 (at least one bit).
  function automatic int unsigned count_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wiper_tick_gen.sv
module wiper_tick_gen #(
  parameter int unsigned HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic tick_o
);
  import wiper_spi_pkg::*;

  localparam int unsigned CW = count_bits(HALF);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF - 1));
  assign tick_o = at_end && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i || at_end) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // Ticks are spaced by a full half period (R4).
  if (HALF > 1) begin : g_spacing
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
  end

endmodule

// File: rtl/wiper_trigger.sv
module wiper_trigger #(
  parameter int unsigned W    = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] value_i,
  input  logic         start_i,
  input  logic         accept_i,
  output logic [W-1:0] value_o,
  output logic         fire_o
);

  logic [SYNC-1:0][W-1:0] sync_q;
  logic [W-1:0]           last_q;
  logic                   changed;

  if (SYNC == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= value_i;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC-2:0], value_i};
    end
  end

  assign value_o = sync_q[SYNC-1];
  assign changed = (value_o != last_q);
  assign fire_o  = changed || start_i;

  // Record the value sent once a frame is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= '0;
    else if (accept_i) last_q <= value_o;
  end

  // A captured value becomes the reference for change detection (R8).
  assert_capture_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (last_q == $past(value_o)));

  // Without a strobe, an unchanged value never fires (R2).
  assert_quiet_when_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (value_o == last_q)) |-> !fire_o);

endmodule

// File: rtl/wiper_frame_seq.sv
module wiper_frame_seq #(
  parameter int unsigned             W          = 8,
  parameter int unsigned             INSTR_W    = 8,
  parameter logic [INSTR_W-1:0]      INSTR_CODE = 8'hDF,
  parameter int unsigned             GAP_HALVES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire_i,
  input  logic [W-1:0] value_i,
  input  logic         tick_i,
  output logic         accept_o,
  output logic         tick_clear_o,
  output logic         sclk_o,
  output logic         cs_n_o,
  output logic         mosi_o,
  output logic         busy_o,
  output logic         done_o
);
  import wiper_spi_pkg::*;

  localparam int unsigned FB     = INSTR_W + W;
  localparam int unsigned HALVES = 2 * FB;
  localparam int unsigned HW     = count_bits(HALVES + GAP_HALVES + 1);
  localparam int unsigned GW     = count_bits(GAP_HALVES + 1) + 1;
  localparam int unsigned RW     = count_bits(FB + 2) + 1;

  function automatic logic [FB-1:0] build_frame(input logic [W-1:0] d);
    return {INSTR_CODE, d};
  endfunction

  seq_state_e    state_q;
  logic [FB-1:0] shreg_q;
  logic [HW-1:0] half_q;
  logic          sclk_q, cs_n_q, done_q;

  // Named internal events.
  logic rise_ev, fall_ev, last_fall, gap_end;

  assign accept_o     = (state_q == SEQ_IDLE) && fire_i;
  assign tick_clear_o = accept_o;
  assign rise_ev      = (state_q == SEQ_SHIFT) && tick_i && !sclk_q;
  assign fall_ev      = (state_q == SEQ_SHIFT) && tick_i && sclk_q;
  assign last_fall    = fall_ev && (half_q == HW'(HALVES - 1));
  assign gap_end      = (state_q == SEQ_GAP) && tick_i && (half_q == HW'(GAP_HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      shreg_q <= '0;
      half_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= gap_end;
      case (state_q)
        SEQ_IDLE: begin
          if (accept_o) begin
            shreg_q <= build_frame(value_i);
            cs_n_q  <= 1'b0;
            sclk_q  <= 1'b0;
            half_q  <= '0;
            state_q <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: begin
          if (tick_i) begin
            half_q <= half_q + 1'b1;
            if (rise_ev) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last_fall) begin
                cs_n_q  <= 1'b1;
                half_q  <= '0;
                state_q <= SEQ_GAP;
              end else begin
                shreg_q <= shreg_q << 1;
              end
            end
          end
        end
        SEQ_GAP: begin
          if (tick_i) begin
            half_q <= half_q + 1'b1;
            if (gap_end) begin
              half_q  <= '0;
              state_q <= SEQ_IDLE;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = !cs_n_q && shreg_q[FB-1];
  assign busy_o = (state_q != SEQ_IDLE);
  assign done_o = done_q;

  // Checker state: ticks seen while deselected, rises seen in a frame.
  logic [GW-1:0] hi_ticks_q;
  logic [RW-1:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks_q <= GW'(GAP_HALVES);
      rises_q    <= '0;
    end else begin
      if (!cs_n_q)                                       hi_ticks_q <= '0;
      else if (tick_i && hi_ticks_q < GW'(GAP_HALVES))    hi_ticks_q <= hi_ticks_q + 1'b1;
      if (accept_o)     rises_q <= '0;
      else if (rise_ev) rises_q <= rises_q + 1'b1;
    end
  end

  assert_sclk_low_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  assert_rise_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (rises_q == RW'(FB)));

  assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o) && !$stable(mosi_o)) |-> !sclk_o);

  assert_gap_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(hi_ticks_q) >= GW'(GAP_HALVES)));

  assert_done_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_no_restart_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(!busy_o));

endmodule

// File: rtl/wiper_spi_writer.sv
module wiper_spi_writer #(
  parameter int unsigned        CLK_HZ      = 50_000_000,
  parameter int unsigned        SCLK_HZ     = 5_000_000,
  parameter int unsigned        VALUE_W     = 8,
  parameter int unsigned        INSTR_W     = 8,
  parameter logic [INSTR_W-1:0] INSTR_CODE  = 8'hDF,
  parameter int unsigned        SYNC_STAGES = 2,
  parameter int unsigned        GAP_PERIODS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VALUE_W-1:0] value_i,
  input  logic               start_i,
  output logic               spi_sclk_o,
  output logic               spi_cs_n_o,
  output logic               spi_mosi_o,
  output logic               busy_o,
  output logic               done_o
);
  import wiper_spi_pkg::*;

  localparam int unsigned HALF       = half_period_cycles(CLK_HZ, SCLK_HZ);
  localparam int unsigned GAP_HALVES = 2 * GAP_PERIODS;

  logic               tick, tick_clear, accept, fire;
  logic [VALUE_W-1:0] value_sync;

  wiper_tick_gen #(.HALF(HALF)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (tick_clear),
    .tick_o  (tick)
  );

  wiper_trigger #(.W(VALUE_W), .SYNC(SYNC_STAGES)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .value_i  (value_i),
    .start_i  (start_i),
    .accept_i (accept),
    .value_o  (value_sync),
    .fire_o   (fire)
  );

  wiper_frame_seq #(
    .W          (VALUE_W),
    .INSTR_W    (INSTR_W),
    .INSTR_CODE (INSTR_CODE),
    .GAP_HALVES (GAP_HALVES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire),
    .value_i      (value_sync),
    .tick_i       (tick),
    .accept_o     (accept),
    .tick_clear_o (tick_clear),
    .sclk_o       (spi_sclk_o),
    .cs_n_o       (spi_cs_n_o),
    .mosi_o       (spi_mosi_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

endmodule

// File: tb/wiper_spi_writer_tb.sv
module wiper_spi_writer_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int H          = 50_000_000 / (2 * 5_000_000); // half period in cycles
  localparam int GAP_H      = 2;                            // quiet halves
  localparam int ON_CYC     = 32 * H;
  localparam int END_CYC    = (32 + GAP_H) * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] value_i = 8'h00;
  logic       start_i = 1'b0;
  logic       sclk, cs_n, mosi, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wiper_spi_writer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .value_i    (value_i),
    .start_i    (start_i),
    .spi_sclk_o (sclk),
    .spi_cs_n_o (cs_n),
    .spi_mosi_o (mosi),
    .busy_o     (busy),
    .done_o     (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cycles, act, exp);
    end
  endtask

  // Reference model, advanced on every rising edge.
  bit          m_active = 0, m_done = 0;
  int          m_k = 0;
  logic [15:0] m_frame = '0;
  logic [7:0]  m_last = '0, s1 = '0, s2 = '0;
  logic [15:0] exp_frames[$];
  int          frames_started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_done = 0; m_k = 0; m_last = '0; s1 = '0; s2 = '0;
    end else begin
      bit trig;
      trig   = !m_active && (start_i || (s2 != m_last));
      m_done = 0;
      if (m_active) begin
        m_k++;
        if (m_k == END_CYC) begin
          m_active = 0;
          m_done   = 1;
        end
      end else if (trig) begin // R2 frame start
        m_active = 1;
        m_k      = 0;
        m_frame  = {8'hDF, s2};
        m_last   = s2;
        exp_frames.push_back(m_frame);
        frames_started++;
      end
      s2 = s1;
      s1 = value_i;
    end
  end

  // Per-cycle comparison and serial decoder, sampled on the falling edge.
  bit          prev_sclk = 0, prev_cs = 1, prev_mosi = 0;
  logic [15:0] rx = '0;
  int          rx_bits = 0;
  int          frames_seen = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit on, e_sclk, e_mosi;
      int hi;
      on     = m_active && (m_k < ON_CYC);
      hi     = m_k / H;
      e_sclk = on && ((hi % 2) == 1);
      e_mosi = on ? m_frame[15 - hi / 2] : 1'b0;
      chk(cs_n == !on, "R6 chip select", cs_n, !on);
      chk(sclk == e_sclk, "R4 serial clock", sclk, e_sclk);
      if (cs_n) chk(mosi == 1'b0, "R10 data idle low", mosi, 0);
      else      chk(mosi == e_mosi, "R3 data bit", mosi, e_mosi);
      chk(busy == m_active, "R7 busy", busy, m_active);
      chk(done == m_done, "R7 done", done, m_done);
      if (prev_sclk && sclk && !cs_n)
        chk(mosi == prev_mosi, "R5 data steady while clock high", mosi, prev_mosi);
      if (prev_cs && !cs_n) begin
        rx = '0; rx_bits = 0;
      end
      if (!prev_sclk && sclk && !cs_n) begin
        rx = {rx[14:0], mosi};
        rx_bits++;
      end
      if (!prev_cs && cs_n) begin
        logic [15:0] ef;
        ef = (exp_frames.size() > 0) ? exp_frames.pop_front() : 16'hXXXX;
        frames_seen++;
        chk(rx_bits == 16, "R4 rising edges per frame", rx_bits, 16);
        chk(rx == ef, "R3/R8 decoded frame", rx, ef);
      end
    end
    prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
  end

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk(0, "R7 done never arrived", 0, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state right after reset
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0,
        "R1 reset state", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    repeat (20) @(negedge clk);
    chk(busy == 0, "R2 unchanged zero value starts nothing", busy, 0);

    value_i = 8'hA5;              // R2 change triggers a frame
    wait_done();

    value_i = 8'h3C;
    repeat (40) @(negedge clk);
    value_i = 8'hFF;              // R8 change deferred to next frame
    pulse_start();                // R9 strobe while busy ignored
    wait_done();
    wait_done();

    pulse_start();                // R9 idle strobe resends 0xFF
    wait_done();

    value_i = 8'h00; wait_done();
    value_i = 8'h80; wait_done();
    value_i = 8'h01; wait_done();

    repeat (60) @(negedge clk);
    chk(busy == 0, "R9 no extra frame after last write", busy, 0);
    chk(frames_started == 7, "R2/R9 frames started", frames_started, 7);
    chk(frames_seen == 7, "R9 frames observed on wire", frames_seen, 7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule